// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a clocked, synthesizable model of a single-port synchronous static memory that has no bus-turnaround penalty. Reads and writes can be issued back to back on every clock, in any mix. The block captures a command on each enabled clock edge. The command comes from three chip selects, a write strobe, an advance/load strobe, per-byte write strobes and an address. The command enters a one-stage pipeline.

A write takes its data on the next enabled edge after the command. A read presents the addressed word during the cycle after the command. A two-bit burst counter steps the low address bits in linear or interleaved order. The burst keeps the read or write type that its loading command chose.

The pipeline stage is a small state machine with three states. `ST_IDLE` means deselected. `ST_READ` means a read access is in progress. `ST_WRITE` means a write access is in progress. The machine has five named transitions:
- LOAD_READ enters `ST_READ`.
- LOAD_WRITE enters `ST_WRITE`.
- DESELECT enters `ST_IDLE`.
- CONTINUE keeps the state while the burst counter steps.
- STALL holds everything while the clock is disabled or sleep is high.

An asynchronous output enable and a sleep input control whether the read data is driven onto the bidirectional bus.

Top module: `zt_sram`

## Requirements
- R1: A new access starts only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0 on an enabled edge with `step_load`=0. Any other select combination with `step_load`=0 moves the machine to `ST_IDLE`. From `ST_IDLE`, nothing is written and nothing is driven.
- R2: After an enabled edge that loads a read (`wr_n`=1), the same cycle shows `rd_drive`=1 and `rd_data` equal to the word at the loaded address.
- R3: After a write is loaded (`wr_n`=0), `wr_data` is stored at the next enabled edge. Any command may be loaded on that same edge, with no idle cycle.
- R4: `lane_wr_n[i]`=0, captured with the command, writes bits [8i+7:8i]. `lane_wr_n[i]`=1 leaves those bits unchanged.
- R5: With `burst_ilv`=0, the n-th access of a burst uses low address bits (start + n) mod 4. The upper bits stay fixed.
- R6: With `burst_ilv`=1, the n-th access of a burst uses low address bits start XOR n.
- R7: `step_load`=1 on an enabled edge steps the burst counter and keeps the current state. The chip selects and `wr_n` are ignored. A burst continued from `ST_IDLE` stays idle.
- R8: When `clk_en_n`=1 at an edge, the edge is ignored. State, counter and memory hold, and a pending write waits for the next enabled edge.
- R9: `rd_drive` is 1 only in `ST_READ` while `out_en_n`=0. `out_en_n` acts without a clock.
- R10: While `sleep`=1, edges are ignored and `rd_drive`=0. `rd_drive` also stays 0 for the first cycle after `sleep` falls.
- R11: Reset puts the machine in `ST_IDLE`, sets `rd_drive`=0 and clears every memory word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel1_n | input | 1 | Chip select 1, active low |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| wr_n | input | 1 | Access type at load: 0 write, 1 read |
| clk_en_n | input | 1 | Clock enable, active low |
| step_load | input | 1 | 1 continues the burst, 0 loads a new command |
| lane_wr_n | input | LANES | Per-byte write strobes, active low |
| addr | input | ADDR_W | Word address |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| wr_data | input | LANES*8 | Write data, one cycle after its command |
| rd_data | output | LANES*8 | Read data for the current access |
| rd_drive | output | 1 | Bus output enable for the read data |

## Verification
Read results fall due in the cycle that follows the enabled edge capturing the command. The bench therefore samples `rd_drive` and `rd_data` 1 ns after each rising edge, once its own model has applied that edge. A write becomes visible at the enabled edge after its command, so a read loaded on that same edge must already return the new word. The bench confirms this, and confirms every ignored write, by reading the address back later. Changes to `out_en_n` are checked inside a cycle, with no edge in between. The first cycle after sleep ends is checked on its own for a quiet bus.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } zt_state_e;

    localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/zt_cmd_fsm.sv
module zt_cmd_fsm
    import zt_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic              wr_n,
    input  logic              step_load,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_wr_n,
    output zt_state_e         state,
    output logic [ADDR_W-1:0] base_addr,
    output logic [1:0]        burst_cnt,
    output logic [LANES-1:0]  lane_q
);

    zt_state_e state_q;
    zt_state_e state_d;
    logic      selected;

    assign selected = !sel1_n && sel2 && !sel3_n;

    // next-state logic: LOAD_READ, LOAD_WRITE, DESELECT, CONTINUE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!step_load && selected)
                    state_d = wr_n ? ST_READ : ST_WRITE;
            end
            ST_READ, ST_WRITE: begin
                if (!step_load) begin
                    if (!selected)
                        state_d = ST_IDLE;
                    else
                        state_d = wr_n ? ST_READ : ST_WRITE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register; STALL when step_en is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else if (step_en)
            state_q <= state_d;
    end

    // burst address and lane capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr <= '0;
            burst_cnt <= '0;
            lane_q    <= '1;
        end else if (step_en) begin
            lane_q <= lane_wr_n;
            if (step_load) begin
                burst_cnt <= burst_cnt + 2'd1;
            end else begin
                base_addr <= addr;
                burst_cnt <= '0;
            end
        end
    end

    assign state = state_q;

    p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(state_q) && $stable(burst_cnt) && $stable(base_addr)));

    p_continue_keeps_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_load) |=> $stable(state_q));

    p_deselect_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !step_load && (sel1_n || !sel2 || sel3_n)) |=> (state_q == ST_IDLE));

    p_counter_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_load) |=> (burst_cnt == $past(burst_cnt) + 2'd1));

endmodule

// File: rtl/zt_burst_addr.sv
module zt_burst_addr #(
    parameter int unsigned ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [1:0]        burst_cnt,
    input  logic              burst_ilv,
    output logic [ADDR_W-1:0] eff_addr
);

    logic [1:0] low_bits;

    always_comb begin
        if (burst_ilv)
            low_bits = base_addr[1:0] ^ burst_cnt;
        else
            low_bits = base_addr[1:0] + burst_cnt;
    end

    generate
        if (ADDR_W > 2) begin : g_wide
            assign eff_addr = {base_addr[ADDR_W-1:2], low_bits};
        end else begin : g_narrow
            assign eff_addr = low_bits;
        end
    endgenerate

endmodule

// File: rtl/zt_mem_array.sv
module zt_mem_array
    import zt_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    generate
        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            logic [LANE_W-1:0] bank [DEPTH];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int w = 0; w < DEPTH; w++)
                        bank[w] <= '0;
                end else if (wr_en && !lane_wr_n[ln]) begin
                    bank[acc_addr] <= wr_data[ln*LANE_W +: LANE_W];
                end
            end

            assign rd_data[ln*LANE_W +: LANE_W] = bank[acc_addr];
        end
    endgenerate

endmodule

// File: rtl/zt_bus_ctrl.sv
module zt_bus_ctrl
    import zt_sram_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sleep,
    input  logic      out_en_n,
    input  zt_state_e state,
    output logic      rd_drive
);

    logic wake_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wake_q <= 1'b0;
        else
            wake_q <= sleep;
    end

    assign rd_drive = (state == ST_READ) && !out_en_n && !sleep && !wake_q;

    p_quiet_in_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rd_drive);

    p_quiet_after_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep) |-> !rd_drive);

    p_drive_needs_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> (state == ST_READ && !out_en_n));

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    wr_n,
    input  logic                    clk_en_n,
    input  logic                    step_load,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    burst_ilv,
    input  logic                    out_en_n,
    input  logic                    sleep,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_drive
);

    zt_state_e         state;
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] eff_addr;
    logic [1:0]        burst_cnt;
    logic [LANES-1:0]  lane_q;
    logic              step_en;
    logic              commit;

    assign step_en = !clk_en_n && !sleep;
    assign commit  = step_en && (state == ST_WRITE);

    zt_cmd_fsm #(.ADDR_W(ADDR_W), .LANES(LANES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .sel1_n    (sel1_n),
        .sel2      (sel2),
        .sel3_n    (sel3_n),
        .wr_n      (wr_n),
        .step_load (step_load),
        .addr      (addr),
        .lane_wr_n (lane_wr_n),
        .state     (state),
        .base_addr (base_addr),
        .burst_cnt (burst_cnt),
        .lane_q    (lane_q)
    );

    zt_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
        .base_addr (base_addr),
        .burst_cnt (burst_cnt),
        .burst_ilv (burst_ilv),
        .eff_addr  (eff_addr)
    );

    zt_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (commit),
        .acc_addr  (eff_addr),
        .lane_wr_n (lane_q),
        .wr_data   (wr_data),
        .rd_data   (rd_data)
    );

    zt_bus_ctrl u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep),
        .out_en_n (out_en_n),
        .state    (state),
        .rd_drive (rd_drive)
    );

    p_no_write_while_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_n || sleep) |-> !commit);

endmodule

// File: tb/zt_sram_bench.sv
module zt_sram_bench;

    localparam int AW = 6;
    localparam int NL = 2;
    localparam int DW = NL * 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [2:0] SEL = 3'b010; // {sel1_n, sel2, sel3_n}
    localparam logic [2:0] DES = 3'b110;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
    logic          wr_n = 1'b1, clk_en_n = 1'b0, step_load = 1'b0;
    logic [NL-1:0] lane_wr_n = '1;
    logic [AW-1:0] addr = '0;
    logic          burst_ilv = 1'b0, out_en_n = 1'b0, sleep = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_drive;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    logic [DW-1:0] ref_mem [DEPTH];
    int            m_op = 0;      // 0 idle, 1 read, 2 write
    logic [AW-1:0] m_base = '0;
    int            m_cnt = 0;
    logic [NL-1:0] m_lane = '1;
    bit            m_wake = 0;

    always #2 clk = ~clk;

    zt_sram #(.ADDR_W(AW), .LANES(NL)) u_zt_sram (
        .clk(clk), .rst_n(rst_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .wr_n(wr_n), .clk_en_n(clk_en_n), .step_load(step_load), .lane_wr_n(lane_wr_n),
        .addr(addr), .burst_ilv(burst_ilv), .out_en_n(out_en_n), .sleep(sleep),
        .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    function automatic logic [AW-1:0] m_eff();
        int lo;
        if (burst_ilv) lo = (m_base % 4) ^ m_cnt;
        else           lo = ((m_base % 4) + m_cnt) % 4;
        return AW'((m_base / 4) * 4 + lo);
    endfunction

    task automatic model_edge();
        bit sel_ok;
        sel_ok = (sel1_n == 1'b0) && (sel2 == 1'b1) && (sel3_n == 1'b0);
        if (!clk_en_n && !sleep) begin
            if (m_op == 2) begin
                for (int ln = 0; ln < NL; ln++)
                    if (!m_lane[ln]) ref_mem[m_eff()][ln*8 +: 8] = wr_data[ln*8 +: 8];
            end
            if (step_load) begin
                m_cnt = (m_cnt + 1) % 4;
            end else begin
                m_base = addr;
                m_cnt  = 0;
                m_op   = sel_ok ? (wr_n ? 1 : 2) : 0;
            end
            m_lane = lane_wr_n;
        end
        m_wake = sleep;
    endtask

    task automatic check(input string tag);
        logic          exp_drv;
        logic [DW-1:0] exp_dat;
        exp_drv = (m_op == 1) && !out_en_n && !sleep && !m_wake;
        checks++;
        if (rd_drive !== exp_drv) begin
            fails++;
            $display("FAIL %s: rd_drive got %0b expected %0b at %0t", tag, rd_drive, exp_drv, $time);
        end
        if (exp_drv) begin
            exp_dat = ref_mem[m_eff()];
            checks++;
            if (rd_data !== exp_dat) begin
                fails++;
                $display("FAIL %s: rd_data got %h expected %h at %0t", tag, rd_data, exp_dat, $time);
            end
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_edge();
        #1;
        check(tag);
    endtask

    task automatic put(input logic [2:0] s, input logic w, input logic ld,
                       input logic [AW-1:0] a, input logic [NL-1:0] ln, input logic [DW-1:0] d);
        {sel1_n, sel2, sel3_n} = s;
        wr_n = w; step_load = ld; addr = a; lane_wr_n = ln; wr_data = d;
    endtask

    task automatic step(input string tag, input logic [2:0] s, input logic w, input logic ld,
                        input logic [AW-1:0] a, input logic [NL-1:0] ln, input logic [DW-1:0] d);
        put(s, w, ld, a, ln, d);
        cyc(tag);
    endtask

    initial begin : watchdog
        #(4 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        #9;
        check("R11 reset bus quiet");
        rst_n = 1'b1;

        // R11: read after reset returns zero
        step("R11", SEL, 1'b1, 1'b0, 6'd5, 2'b00, 16'h0);
        step("R11", DES, 1'b1, 1'b0, 6'd0, 2'b00, 16'h0);

        // R3/R2: mixed stream with no idle cycles
        step("R3 write A1",        SEL, 1'b0, 1'b0, 6'd8,  2'b00, 16'h0000);
        step("R3 write A2",        SEL, 1'b0, 1'b0, 6'd12, 2'b00, 16'h1111);
        step("R3 burst write",     SEL, 1'b1, 1'b1, 6'd0,  2'b00, 16'h2222);
        step("R2 read A3",         SEL, 1'b1, 1'b0, 6'd8,  2'b00, 16'h3333);
        step("R2 read A4",         SEL, 1'b1, 1'b0, 6'd12, 2'b00, 16'h0);
        step("R2 burst read",      DES, 1'b1, 1'b1, 6'd0,  2'b00, 16'h0);
        step("R3 write A5",        SEL, 1'b0, 1'b0, 6'd20, 2'b00, 16'h0);
        step("R3 read after write",SEL, 1'b1, 1'b0, 6'd20, 2'b00, 16'h5555);
        step("R3 write A7",        SEL, 1'b0, 1'b0, 6'd33, 2'b00, 16'h0);
        step("R1 deselect",        DES, 1'b1, 1'b0, 6'd0,  2'b00, 16'h7777);
        step("R3 readback",        SEL, 1'b1, 1'b0, 6'd33, 2'b00, 16'h0);
        step("R3 readback",        SEL, 1'b1, 1'b0, 6'd13, 2'b00, 16'h0);

        // R4: byte lanes
        step("R4", SEL, 1'b0, 1'b0, 6'd40, 2'b00, 16'h0);
        step("R4", SEL, 1'b0, 1'b0, 6'd40, 2'b10, 16'hFFFF);
        step("R4", SEL, 1'b0, 1'b0, 6'd40, 2'b01, 16'h1234);
        step("R4", SEL, 1'b1, 1'b0, 6'd40, 2'b00, 16'hAB00);
        step("R4 lanes merged", DES, 1'b1, 1'b0, 6'd0, 2'b00, 16'h0);

        // fill 48..51 with distinct words
        for (int k = 0; k < 4; k++) begin
            step("R3 fill", SEL, 1'b0, 1'b0, AW'(48 + k), 2'b00, DW'(16'hC0DE + k*3));
        end
        step("R3 fill", DES, 1'b1, 1'b0, 6'd0, 2'b00, DW'(16'hC0DE + 9));

        // R5: linear burst from 49
        burst_ilv = 1'b0;
        step("R5 linear", SEL, 1'b1, 1'b0, 6'd49, 2'b00, 16'h0);
        for (int k = 0; k < 3; k++) step("R5 linear", SEL, 1'b1, 1'b1, 6'd0, 2'b00, 16'h0);
        // R6: interleaved burst from 49
        burst_ilv = 1'b1;
        step("R6 interleaved", SEL, 1'b1, 1'b0, 6'd49, 2'b00, 16'h0);
        for (int k = 0; k < 3; k++) step("R6 interleaved", SEL, 1'b1, 1'b1, 6'd0, 2'b00, 16'h0);
        // R6: interleaved burst write from 54, then linear readback
        step("R6 burst write", SEL, 1'b0, 1'b0, 6'd54, 2'b00, 16'h0);
        for (int k = 0; k < 3; k++) step("R6 burst write", SEL, 1'b0, 1'b1, 6'd0, 2'b00, DW'(16'h6000 + k));
        step("R6 burst write", DES, 1'b1, 1'b0, 6'd0, 2'b00, 16'h6003);
        burst_ilv = 1'b0;
        for (int k = 0; k < 4; k++) step("R6 readback", SEL, 1'b1, 1'b0, AW'(52 + k), 2'b00, 16'h0);

        // R1: every non-selecting combination blocks a write to 60
        for (int c = 0; c < 8; c++) begin
            if (3'(c) != SEL) begin
                step("R1 no select", 3'(c), 1'b0, 1'b0, 6'd60, 2'b00, 16'h0);
                step("R1 no select", DES, 1'b1, 1'b0, 6'd0, 2'b00, 16'h5A5A);
            end
        end
        step("R1 readback", SEL, 1'b1, 1'b0, 6'd60, 2'b00, 16'h0);

        // R7: continue ignores selects and wr_n
        step("R7", SEL, 1'b1, 1'b0, 6'd48, 2'b00, 16'h0);
        step("R7 keeps read", DES, 1'b0, 1'b1, 6'd0, 2'b00, 16'h0);
        step("R7 keeps read", 3'b001, 1'b0, 1'b1, 6'd0, 2'b00, 16'h0);
        step("R7", DES, 1'b1, 1'b0, 6'd0, 2'b00, 16'h0);
        step("R7 idle stays", SEL, 1'b0, 1'b1, 6'd0, 2'b00, 16'h9999);
        step("R7 idle stays", SEL, 1'b0, 1'b1, 6'd0, 2'b00, 16'h9999);
        step("R7 readback", SEL, 1'b1, 1'b0, 6'd48, 2'b00, 16'h0);

        // R8: stall between write command and its data
        step("R8", SEL, 1'b0, 1'b0, 6'd56, 2'b00, 16'h0);
        clk_en_n = 1'b1;
        step("R8 stall", SEL, 1'b1, 1'b0, 6'd10, 2'b00, 16'hDEAD);
        step("R8 stall", SEL, 1'b1, 1'b0, 6'd11, 2'b00, 16'hBEEF);
        clk_en_n = 1'b0;
        step("R8", SEL, 1'b1, 1'b0, 6'd56, 2'b00, 16'h4242);
        step("R8 burst", SEL, 1'b1, 1'b1, 6'd0, 2'b00, 16'h0);
        clk_en_n = 1'b1;
        step("R8 hold output", SEL, 1'b0, 1'b0, 6'd3, 2'b00, 16'h0);
        clk_en_n = 1'b0;
        step("R8", DES, 1'b1, 1'b0, 6'd0, 2'b00, 16'h0);

        // R9: asynchronous output enable
        step("R9", SEL, 1'b1, 1'b0, 6'd20, 2'b00, 16'h0);
        out_en_n = 1'b1; #1; check("R9 oe off");
        out_en_n = 1'b0; #1; check("R9 oe on");
        out_en_n = 1'b1;
        step("R9 oe off", SEL, 1'b1, 1'b1, 6'd0, 2'b00, 16'h0);
        out_en_n = 1'b0;
        step("R9 write no drive", SEL, 1'b0, 1'b0, 6'd61, 2'b00, 16'h0);

        // R10: sleep
        step("R10", SEL, 1'b1, 1'b0, 6'd8, 2'b00, 16'h6161);
        sleep = 1'b1; #1; check("R10 sleep quiet");
        step("R10 sleep", SEL, 1'b0, 1'b0, 6'd8, 2'b00, 16'hFFFF);
        step("R10 sleep", SEL, 1'b0, 1'b0, 6'd8, 2'b00, 16'hFFFF);
        sleep = 1'b0; #1; check("R10 exit quiet");
        step("R10 exit", SEL, 1'b1, 1'b1, 6'd0, 2'b00, 16'h0);
        step("R10 readback", SEL, 1'b1, 1'b0, 6'd8, 2'b00, 16'h0);

        // random mixed stream
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] s;
            s = ($urandom % 4 != 0) ? SEL : 3'($urandom);
            clk_en_n  = ($urandom % 10 == 0);
            sleep     = ($urandom % 40 == 0);
            out_en_n  = ($urandom % 12 == 0);
            burst_ilv = ($urandom % 2 == 1);
            put(s, 1'($urandom), ($urandom % 3 == 0), AW'($urandom), NL'($urandom), DW'($urandom));
            cyc("R2 R3 R5 R6 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule